// File: doc/BRIEF.md
# Stereo Soft-Mute and Analog-Mute Sequencer

This block sits in a stereo audio data path and scales every incoming sample pair by a gain taken from a logarithmic attenuation index. The index moves by one 1 dB step on each sample strobe. It moves down toward silence while any mute cause is present and back up toward unity once every cause has cleared. Once the digital level has reached silence, the block raises a separate analog-mute line. The same line is also raised for two other reasons: a long run of silent input, and an undervoltage collapse.

There are four mute causes: a soft-mute (play) input, a fault flag raised by clock or link checkers elsewhere in the chip, and two undervoltage comparator flags with a high and a low threshold. While the fault flag is set, the last good input pair is repeated in place of live data, so the ramp fades a known-good signal. The undervoltage path is armed only when the high-threshold flag has been present for a long time before the low-threshold flag trips, which marks a slowly falling supply. In that case the low flag forces analog mute at once, whatever the digital level.

Top module: `smute_ctrl`

## Requirements
- R1: During and straight after reset, both sample outputs are 0, analog mute is low and the attenuation is 0 dB.
- R2: At 0 dB, each output sample equals its input sample bit for bit. The output register updates on the clock edge that carries the strobe.
- R3: While a mute cause is present, the n-th strobe (n counted from 1) outputs the input scaled by 10^(-(n-1)/20), within a few LSB. The ramp reaches the bottom index 104 after 104 strobes, and from then on the outputs are exactly 0.
- R4: Analog mute rises at the strobe that brings the ramp to index 104 and not before. It falls at the first strobe that steps the ramp back up.
- R5: With no mute cause, the ramp climbs one index per strobe. The strobe that starts the climb from the bottom still outputs 0, and 104 strobes later the output is back at unity.
- R6: A change of request partway through a ramp reverses direction from the current index. The next strobe uses the index already reached, with no jump.
- R7: After 1024 consecutive strobes on which both channel inputs are 0, analog mute rises. A nonzero value on either channel clears the run count and releases this mute on that strobe.
- R8: While the fault flag is high, the last input pair taken with the fault low is used in place of the live inputs, and the ramp falls exactly as in R3. Analog mute follows R4.
- R9: The high-threshold undervoltage flag on its own is a mute cause and starts the down ramp.
- R10: If the high-threshold flag has been held for at least SLOW_CYC clock cycles, the low-threshold flag forces analog mute one clock later, whatever the attenuation. The force stays until the high-threshold flag clears.
- R11: If the low-threshold flag arrives before the high-threshold flag has been held SLOW_CYC cycles, it only acts as a mute cause and does not force analog mute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_stb_i | input | 1 | One-cycle strobe marking a new sample pair |
| smp_l_i | input | DW | Left input sample, two's complement |
| smp_r_i | input | DW | Right input sample, two's complement |
| play_i | input | 1 | 1 = play, 0 = soft-mute request |
| fault_i | input | 1 | Clock or link fault from other blocks |
| uv_hi_i | input | 1 | Supply below the upper undervoltage threshold |
| uv_lo_i | input | 1 | Supply below the lower undervoltage threshold |
| smp_l_o | output | DW | Left sample with gain applied |
| smp_r_o | output | DW | Right sample with gain applied |
| amute_o | output | 1 | Analog-mute request |

## Verification
The gain path is driven with full-scale positive and negative values, which exposes any loss of exactness at unity and any sign error in the product. A constant 2^15 input makes each output word equal to the coefficient itself, so every step of the curve is compared against the ideal decibel law. The same ramp is then run from four sources: the play pin, the fault flag (whose fresh input differs from the held one), the undervoltage flags, and a request reversed partway down. These runs separate the ramp control from the choice of sample. The zero-run counter is fed a broken run and then an unbroken one, so a counter that fails to clear can be told apart from one that counts correctly. The undervoltage force is tried with a long and a short lead of the upper flag, so the slow-fall qualification is exercised both ways.

// File: rtl/smute_pkg.sv
package smute_pkg;
  localparam int COEF_W    = 16;
  localparam int COEF_FRAC = 15;
  localparam int ATT_MAX   = 104;
  localparam int ATT_W     = $clog2(ATT_MAX + 1);
  // round(2^16 * 10^(-1/20))
  localparam int STEP_NUM  = 58409;

  typedef logic [ATT_W-1:0]  att_t;
  typedef logic [COEF_W-1:0] coef_t;
  typedef coef_t coef_tab_t [ATT_MAX+1];
  typedef enum logic {RAMP_UP = 1'b0, RAMP_DN = 1'b1} ramp_dir_e;

  function automatic coef_tab_t build_coef();
    coef_tab_t  t;
    logic [31:0] g;
    g = 32'd1 << COEF_FRAC;
    for (int i = 0; i < ATT_MAX; i++) begin
      t[i] = g[COEF_W-1:0];
      g    = (g * 32'(STEP_NUM) + 32'd32768) >> 16;
    end
    t[ATT_MAX] = '0;
    return t;
  endfunction
endpackage

// File: rtl/smute_ramp.sv
module smute_ramp
  import smute_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stb_i,
  input  logic mute_i,
  output att_t att_o
);
  ramp_dir_e dir;
  att_t      att_q;

  assign dir = mute_i ? RAMP_DN : RAMP_UP;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      att_q <= '0;
    end else if (stb_i) begin
      if (dir == RAMP_DN && att_q != att_t'(ATT_MAX)) att_q <= att_q + 1'b1;
      else if (dir == RAMP_UP && att_q != '0)        att_q <= att_q - 1'b1;
    end
  end

  assign att_o = att_q;
endmodule

// File: rtl/smute_gain.sv
module smute_gain
  import smute_pkg::*;
#(
  parameter int DW = 24
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 stb_i,
  input  att_t                 att_i,
  input  logic signed [DW-1:0] smp_i,
  output logic signed [DW-1:0] smp_o
);
  localparam int PW = DW + COEF_W + 1;
  localparam coef_tab_t COEF_TAB = build_coef();

  coef_t                 coef;
  logic signed [PW-1:0]  prod;
  logic signed [DW-1:0]  scaled;
  logic signed [DW-1:0]  out_q;

  assign coef   = COEF_TAB[att_i];
  assign prod   = PW'(smp_i) * PW'($signed({1'b0, coef}));
  assign scaled = DW'(prod >>> COEF_FRAC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    out_q <= '0;
    else if (stb_i) out_q <= scaled;
  end

  assign smp_o = out_q;
endmodule

// File: rtl/smute_zero_det.sv
module smute_zero_det #(
  parameter int DW  = 24,
  parameter int RUN = 1024
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          stb_i,
  input  logic [DW-1:0] l_i,
  input  logic [DW-1:0] r_i,
  output logic          hit_o
);
  localparam int CW = $clog2(RUN + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (stb_i) begin
      if (l_i == '0 && r_i == '0) begin
        if (cnt_q != CW'(RUN)) cnt_q <= cnt_q + 1'b1;
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign hit_o = (cnt_q == CW'(RUN));
endmodule

// File: rtl/smute_uv_det.sv
module smute_uv_det #(
  parameter int SLOW_CYC = 1500000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic uv_hi_i,
  input  logic uv_lo_i,
  output logic mode_o,
  output logic force_o
);
  localparam int CW = $clog2(SLOW_CYC + 1);
  logic [CW-1:0] cnt_q;
  logic          force_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (!uv_hi_i)                cnt_q <= '0;
    else if (cnt_q != CW'(SLOW_CYC))  cnt_q <= cnt_q + 1'b1;
  end

  assign mode_o = (cnt_q == CW'(SLOW_CYC));

  // slow fall qualified: low threshold forces analog mute until recovery
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                force_q <= 1'b0;
    else if (!uv_hi_i)          force_q <= 1'b0;
    else if (mode_o && uv_lo_i) force_q <= 1'b1;
  end

  assign force_o = force_q;
endmodule

// File: rtl/smute_ctrl.sv
module smute_ctrl
  import smute_pkg::*;
#(
  parameter int DW       = 24,
  parameter int ZERO_RUN = 1024,
  parameter int SLOW_CYC = 1500000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          smp_stb_i,
  input  logic [DW-1:0] smp_l_i,
  input  logic [DW-1:0] smp_r_i,
  input  logic          play_i,
  input  logic          fault_i,
  input  logic          uv_hi_i,
  input  logic          uv_lo_i,
  output logic [DW-1:0] smp_l_o,
  output logic [DW-1:0] smp_r_o,
  output logic          amute_o
);
  localparam int NCH = 2;

  logic signed [DW-1:0] raw    [NCH];
  logic signed [DW-1:0] held_q [NCH];
  logic signed [DW-1:0] eff    [NCH];
  logic signed [DW-1:0] outs   [NCH];
  logic                 mute_cause;
  logic                 zero_mute;
  logic                 uv_mode;
  logic                 uv_force;
  att_t                 att_q;

  assign raw[0] = $signed(smp_l_i);
  assign raw[1] = $signed(smp_r_i);

  assign mute_cause = !play_i || fault_i || uv_hi_i || uv_lo_i;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     held_q[c] <= '0;
      else if (smp_stb_i && !fault_i)  held_q[c] <= raw[c];
    end

    assign eff[c] = fault_i ? held_q[c] : raw[c];

    smute_gain #(.DW(DW)) i_gain (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .stb_i  (smp_stb_i),
      .att_i  (att_q),
      .smp_i  (eff[c]),
      .smp_o  (outs[c])
    );
  end

  smute_ramp i_ramp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stb_i  (smp_stb_i),
    .mute_i (mute_cause),
    .att_o  (att_q)
  );

  smute_zero_det #(.DW(DW), .RUN(ZERO_RUN)) i_zero (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stb_i  (smp_stb_i),
    .l_i    (eff[0]),
    .r_i    (eff[1]),
    .hit_o  (zero_mute)
  );

  smute_uv_det #(.SLOW_CYC(SLOW_CYC)) i_uv (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .uv_hi_i (uv_hi_i),
    .uv_lo_i (uv_lo_i),
    .mode_o  (uv_mode),
    .force_o (uv_force)
  );

  assign smp_l_o = outs[0];
  assign smp_r_o = outs[1];
  assign amute_o = zero_mute || uv_force || (att_q == att_t'(ATT_MAX));
endmodule

// File: rtl/smute_ctrl_chk.sv
module smute_ctrl_chk
  import smute_pkg::*;
#(
  parameter int DW = 24
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          smp_stb_i,
  input logic [DW-1:0] smp_l_i,
  input logic [DW-1:0] smp_r_i,
  input logic          play_i,
  input logic          fault_i,
  input logic          uv_hi_i,
  input logic          uv_lo_i,
  input logic [DW-1:0] smp_l_o,
  input logic [DW-1:0] smp_r_o,
  input logic          amute_o,
  input att_t          att_i,
  input logic          uv_mode_i
);
  assert_att_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_stb_i |=> $stable(att_i));

  assert_att_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_stb_i |=> (att_i == $past(att_i)) || (att_i == $past(att_i) + 1'b1)
                  || (att_i + 1'b1 == $past(att_i)));

  assert_unity_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_stb_i && !fault_i && att_i == '0
      |=> smp_l_o == $past(smp_l_i) && smp_r_o == $past(smp_r_i));

  assert_bottom_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_stb_i && att_i == att_t'(ATT_MAX) |=> smp_l_o == '0 && smp_r_o == '0);

  assert_climb_start_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_stb_i && att_i == att_t'(ATT_MAX) && play_i && !fault_i && !uv_hi_i && !uv_lo_i
      |=> att_i == att_t'(ATT_MAX - 1));

  assert_uv_force_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uv_mode_i && uv_lo_i |=> amute_o);

  assert_bottom_amute_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    att_i == att_t'(ATT_MAX) |-> amute_o);
endmodule

bind smute_ctrl smute_ctrl_chk #(.DW(DW)) i_smute_ctrl_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .smp_stb_i (smp_stb_i),
  .smp_l_i   (smp_l_i),
  .smp_r_i   (smp_r_i),
  .play_i    (play_i),
  .fault_i   (fault_i),
  .uv_hi_i   (uv_hi_i),
  .uv_lo_i   (uv_lo_i),
  .smp_l_o   (smp_l_o),
  .smp_r_o   (smp_r_o),
  .amute_o   (amute_o),
  .att_i     (att_q),
  .uv_mode_i (uv_mode)
);

// File: tb/test_smute_ctrl.sv
module test_smute_ctrl;
  localparam int DW     = 24;
  localparam int BOTTOM = 104;
  localparam int SLOW   = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          stb = 1'b0;
  logic [DW-1:0] in_l = '0, in_r = '0;
  logic          play = 1'b1, fault = 1'b0, uv_hi = 1'b0, uv_lo = 1'b0;
  logic [DW-1:0] out_l, out_r;
  logic          amute;

  always #2 clk = ~clk;

  smute_ctrl #(.DW(DW), .ZERO_RUN(1024), .SLOW_CYC(SLOW)) i_smute_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .smp_stb_i(stb), .smp_l_i(in_l), .smp_r_i(in_r),
    .play_i(play), .fault_i(fault), .uv_hi_i(uv_hi), .uv_lo_i(uv_lo),
    .smp_l_o(out_l), .smp_r_o(out_r), .amute_o(amute));

  typedef struct {
    int    el;
    int    er;
    int    tol;
    string tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0, n_fail = 0;
  int   m_att = 0, held_l = 0, held_r = 0;
  logic stb_d = 1'b0;

  function automatic int ideal(int x, int a);
    real g;
    if (a == 0) return x;
    if (a >= BOTTOM) return 0;
    g = $pow(10.0, -a / 20.0);
    return int'(x * g);
  endfunction

  function automatic int tol_of(int x, int a);
    if (a == 0 || a >= BOTTOM) return 0;
    return 2 + 6 * (x < 0 ? -x : x) / 32768;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // driver: model the ramp, push the expectation, drive the strobe
  task automatic step(input int l, input int r, input bit mute, input bit flt, input string tag);
    exp_t e;
    int   ul, ur;
    if (flt) begin ul = held_l; ur = held_r; end
    else begin ul = l; ur = r; held_l = l; held_r = r; end
    e.el  = ideal(ul, m_att);
    e.er  = ideal(ur, m_att);
    e.tol = tol_of(ul, m_att) > tol_of(ur, m_att) ? tol_of(ul, m_att) : tol_of(ur, m_att);
    e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    in_l = DW'(l); in_r = DW'(r); stb = 1'b1;
    @(negedge clk);
    stb = 1'b0;
    repeat (3) @(negedge clk);
    if (mute) begin if (m_att < BOTTOM) m_att++; end
    else if (m_att > 0) m_att--;
  endtask

  always @(posedge clk) stb_d <= stb;

  // monitor: compare each produced pair against the queue head
  always @(negedge clk) begin
    if (stb_d && q.size() > 0) begin
      exp_t e;
      int al, ar, dl, dr;
      e  = q.pop_front();
      al = int'($signed(out_l));
      ar = int'($signed(out_r));
      dl = al - e.el; if (dl < 0) dl = -dl;
      dr = ar - e.er; if (dr < 0) dr = -dr;
      check(dl <= e.tol, {e.tag, " left"}, al, e.el);
      check(dr <= e.tol, {e.tag, " right"}, ar, e.er);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(out_l == '0 && out_r == '0, "R1 outputs in reset", int'(out_l), 0);
    check(amute == 1'b0, "R1 amute in reset", int'(amute), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(amute == 1'b0, "R1 amute after reset", int'(amute), 0);

    // R2 unity pass-through
    step(123456, -777, 0, 0, "R2");
    step(-8388608, 8388607, 0, 0, "R2");
    step(1, -1, 0, 0, "R2");

    // R3 / R4 down ramp
    play = 1'b0;
    for (int i = 0; i < BOTTOM - 1; i++) step(32768, -32768, 1, 0, "R3");
    check(amute == 1'b0, "R4 amute one step before bottom", int'(amute), 0);
    step(32768, -32768, 1, 0, "R3");
    check(amute == 1'b1, "R4 amute at bottom", int'(amute), 1);
    step(32768, -32768, 1, 0, "R3");
    step(500000, -500000, 1, 0, "R3");

    // R5 up ramp, R4 release
    play = 1'b1;
    step(32768, -32768, 0, 0, "R5");
    check(amute == 1'b0, "R4 amute released on climb", int'(amute), 0);
    for (int i = 0; i < BOTTOM - 1; i++) step(32768, 20000, 0, 0, "R5");
    step(-4000000, 3999999, 0, 0, "R5");

    // R6 reversal mid ramp
    play = 1'b0;
    for (int i = 0; i < 40; i++) step(32768, 32768, 1, 0, "R6");
    play = 1'b1;
    for (int i = 0; i < 45; i++) step(32768, -16384, 0, 0, "R6");
    check(amute == 1'b0, "R6 amute stays low", int'(amute), 0);

    // R8 fault holds last good sample
    step(20000, -20000, 0, 0, "R8");
    fault = 1'b1;
    for (int i = 0; i < BOTTOM; i++) step(5, 5, 1, 1, "R8");
    check(amute == 1'b1, "R8 amute after fault ramp", int'(amute), 1);
    fault = 1'b0;
    for (int i = 0; i < BOTTOM; i++) step(32768, 32768, 0, 0, "R8");
    check(amute == 1'b0, "R8 amute after recovery", int'(amute), 0);

    // R7 zero run
    for (int i = 0; i < 600; i++) step(0, 0, 0, 0, "R7");
    step(5, 0, 0, 0, "R7");
    for (int i = 0; i < 1023; i++) step(0, 0, 0, 0, "R7");
    check(amute == 1'b0, "R7 broken run does not mute", int'(amute), 0);
    step(0, 0, 0, 0, "R7");
    check(amute == 1'b1, "R7 mute after 1024 zero pairs", int'(amute), 1);
    step(0, 9, 0, 0, "R7");
    check(amute == 1'b0, "R7 nonzero releases", int'(amute), 0);

    // R9 / R10 slow undervoltage
    uv_hi = 1'b1;
    for (int i = 0; i < 10; i++) step(32768, 32768, 1, 0, "R9");
    check(amute == 1'b0, "R10 no force before low flag", int'(amute), 0);
    uv_lo = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(amute == 1'b1, "R10 forced analog mute", int'(amute), 1);
    uv_lo = 1'b0;
    repeat (2) @(negedge clk);
    check(amute == 1'b1, "R10 force held", int'(amute), 1);
    uv_hi = 1'b0;
    repeat (2) @(negedge clk);
    check(amute == 1'b0, "R10 force cleared", int'(amute), 0);
    for (int i = 0; i < 12; i++) step(32768, 32768, 0, 0, "R9");

    // R11 fast fall
    uv_hi = 1'b1; uv_lo = 1'b1;
    for (int i = 0; i < 3; i++) step(32768, 32768, 1, 0, "R11");
    check(amute == 1'b0, "R11 fast fall no force", int'(amute), 0);
    uv_hi = 1'b0; uv_lo = 1'b0;
    for (int i = 0; i < 4; i++) step(32768, 32768, 0, 0, "R11");

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule